// File: doc/BRIEF.md
# Manchester sample frame transmitter

This block sends 16-bit samples over a single serial line as fixed-length Manchester-coded frames. Each frame takes 48 bit periods. It opens with a run of zero bits so that a receiver can find its place again, then a single one bit that marks the start, then the sample word with the most significant bit first. Frames follow each other without a gap. When no new sample has arrived in time, the frame carries the previous word again.

The block runs from one system clock. A strobe, `half_en`, is high for one clock per half bit period, so it pulses at twice the bit rate. An internal phase toggle serves as the bit clock. The line bit is the bit clock XORed with the current data bit, and a register loads that value so that no gate output drives the pin. Samples enter through a valid/ready port. Ready is high only during the zero run of the current frame, and only while no sample is waiting for the next frame. An accepted sample is copied into the frame register when the next frame begins. While `s_valid` is high and `s_ready` is low, the source must hold `s_valid` and `s_data` steady. The block takes the sample at the first clock edge where both are high.

Top module: `manch_frame_tx`

## Requirements
- R1: After reset, `line_out` is 0 and `s_ready` is 1, and the first frame carries the word 0x0000.
- R2: Each frame is 48 bit periods: 31 zero bits, one start bit of value 1, then the 16 data bits, bit 15 first and bit 0 last.
- R3: Each bit period has two halves. The first half carries the bit value and the second half its complement (line = bit clock XOR data, with the bit clock low in the first half). This gives exactly 48 high halves per frame.
- R4: `line_out` comes from a register and changes only on the clock edge where `half_en` is 1. Each `half_en` pulse moves to the next half bit.
- R5: `s_ready` is high only during bit periods 0 to 30 of a frame, and only while no sample is held for the next frame. With no transfer, it stays high for exactly 31 bit periods from the start of the frame.
- R6: A sample is taken on a clock edge where `s_valid` and `s_ready` are both 1. After that, `s_ready` stays 0 until the next frame begins.
- R7: A sample accepted during a frame's zero run is sent in the data field of the next frame, not the current one.
- R8: If no sample is accepted during a frame, the next frame sends the same data word again.
- R9: `s_valid` while `s_ready` is 0 has no effect. A request held across the rise of `s_ready` is accepted with the data held on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | One-clock strobe at twice the bit rate; advances one half bit |
| s_valid | input | 1 | Source offers a sample |
| s_ready | output | 1 | Block can accept a sample for the next frame |
| s_data | input | 16 | Sample word |
| line_out | output | 1 | Registered Manchester-coded line bit |

## Verification
The bench decodes every frame from the line and checks the zero run, the start bit, the data word, and the complement between half bits. A design that sends data LSB first, lets the two halves match, or miscounts the zero run fails on the first frame. The bench mixes frames with a fresh sample, frames with none, requests raised before ready, and junk requests dropped before ready. A design that loads a sample into the frame in progress, takes data while ready is low, or fails to repeat the old word sends the wrong word in some frame. The bench also measures how long ready stays high and checks that ready drops after a transfer. A design that keeps ready high into the data bits, or accepts two samples in one frame, is reported.

// File: rtl/manch_pkg.sv
package manch_pkg;
  typedef enum logic {HALF_FIRST = 1'b0, HALF_SECOND = 1'b1} half_t;
  localparam int MIN_SYNC_ZEROS = 18;
endpackage

// File: rtl/manch_bit_timer.sv
module manch_bit_timer
  import manch_pkg::*;
#(
  parameter int FRAME_BITS = 48,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_en,
  output logic [IW-1:0] idx,
  output half_t         ph,
  output logic          frame_end,
  output logic [IW-1:0] nxt_idx,
  output half_t         nxt_ph
);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic bit_end;

  always_comb begin
    bit_end   = half_en && (ph == HALF_SECOND);
    frame_end = bit_end && (idx == LAST_IDX);
    if (frame_end)    nxt_idx = '0;
    else if (bit_end) nxt_idx = idx + IW'(1);
    else              nxt_idx = idx;
    if (half_en) nxt_ph = (ph == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
    else         nxt_ph = ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      ph  <= HALF_FIRST;
    end else begin
      idx <= nxt_idx;
      ph  <= nxt_ph;
    end
  end

  // R4: position holds still between strobes
  a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> ($stable(idx) && $stable(ph)));
endmodule

// File: rtl/manch_sample_hold.sv
module manch_sample_hold #(
  parameter int DATA_W     = 16,
  parameter int PRE_ZEROS  = 31,
  parameter int FRAME_BITS = 48,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     idx,
  input  logic              frame_end,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic [DATA_W-1:0] nxt_word
);
  localparam logic [IW-1:0] PRE_IDX = IW'(PRE_ZEROS);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] word_q;
  logic              full_q;
  logic              take;

  always_comb begin
    s_ready  = (idx < PRE_IDX) && !full_q;
    take     = s_valid && s_ready;
    nxt_word = frame_end ? hold_q : word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      word_q <= nxt_word;
      if (take) begin
        hold_q <= s_data;
        full_q <= 1'b1;
      end else if (frame_end) begin
        full_q <= 1'b0;
      end
    end
  end

  // R6: one transfer closes the port for the rest of the frame
  a_r6_one_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !s_ready);
  // R7: the frame word changes only at a frame boundary
  a_r7_word_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(word_q));
  // R5: ready never opens outside the zero run
  a_r5_ready_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= PRE_IDX) |-> !s_ready);
endmodule

// File: rtl/manch_line_enc.sv
module manch_line_enc
  import manch_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PRE_ZEROS  = 31,
  parameter int FRAME_BITS = 48,
  localparam int IW = $clog2(FRAME_BITS),
  localparam int BW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_en,
  input  logic [IW-1:0]     nxt_idx,
  input  half_t             nxt_ph,
  input  logic [DATA_W-1:0] nxt_word,
  output logic              line_q
);
  localparam logic [IW-1:0] PRE_IDX  = IW'(PRE_ZEROS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic [IW-1:0] pos;
  logic          dbit;

  always_comb begin
    pos = LAST_IDX - nxt_idx;
    if (nxt_idx < PRE_IDX)       dbit = 1'b0;
    else if (nxt_idx == PRE_IDX) dbit = 1'b1;
    else                         dbit = nxt_word[pos[BW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= dbit ^ nxt_ph;
  end

  // R3: entering the second half always flips the line
  a_r3_mid_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && nxt_ph == HALF_SECOND) |=> (line_q != $past(line_q)));
endmodule

// File: rtl/manch_frame_tx.sv
module manch_frame_tx
  import manch_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PRE_ZEROS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              line_out
);
  localparam int FRAME_BITS = PRE_ZEROS + 1 + DATA_W;
  localparam int IW = $clog2(FRAME_BITS);

  logic [IW-1:0]     idx, nxt_idx;
  half_t             ph, nxt_ph;
  logic              frame_end;
  logic [DATA_W-1:0] nxt_word;

  manch_bit_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .idx(idx), .ph(ph), .frame_end(frame_end),
    .nxt_idx(nxt_idx), .nxt_ph(nxt_ph)
  );

  manch_sample_hold #(.DATA_W(DATA_W), .PRE_ZEROS(PRE_ZEROS), .FRAME_BITS(FRAME_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .idx(idx), .frame_end(frame_end),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .nxt_word(nxt_word)
  );

  manch_line_enc #(.DATA_W(DATA_W), .PRE_ZEROS(PRE_ZEROS), .FRAME_BITS(FRAME_BITS)) u_enc (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .nxt_idx(nxt_idx), .nxt_ph(nxt_ph), .nxt_word(nxt_word),
    .line_q(line_out)
  );

  // R4: the pin moves only on a half-bit strobe
  a_r4_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(line_out));
  // R2: the start bit opens high after a zero second half
  a_r2_start_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && ph == HALF_SECOND && idx == IW'(PRE_ZEROS - 1)) |=> line_out);
  // R1: the first half bit after reset is low
  a_r1_reset_line: assert property (@(posedge clk)
    !rst_n |=> !line_out);
endmodule

// File: tb/manch_frame_tx_test.sv
module manch_frame_tx_test;
  localparam int NFRAMES = 10;
  localparam int NITER   = NFRAMES - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_en = 1'b0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready;
  logic        line_out;

  int checks = 0;
  int failures = 0;
  bit mon_done = 1'b0;
  logic [15:0] exp_q[$];

  manch_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .line_out(line_out)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // half-bit strobe: one clock in four
  initial begin
    wait (rst_n);
    forever begin
      repeat (3) @(negedge clk);
      half_en = 1'b1;
      @(negedge clk);
      half_en = 1'b0;
    end
  end

  // driver: one iteration per frame, pushes the word expected in the next frame
  initial begin
    int mode [NITER] = '{1, 1, 0, 2, 1, 3, 0, 1, 2};
    logic [15:0] last;
    last = 16'h0000;
    exp_q.push_back(16'h0000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(line_out == 1'b0, "R1 line after reset", line_out, 0);
    check(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);
    for (int i = 0; i < NITER; i++) begin
      logic [15:0] val;
      int hi_cnt;
      val = (16'h1357 * 16'(i + 3)) ^ 16'(i * 16'h0101);
      if (mode[i] == 2) begin
        s_valid = 1'b1; s_data = val;            // R9 request raised early
      end else if (mode[i] == 3) begin
        s_valid = 1'b1; s_data = 16'hFFFF;       // R9 junk while ready low
        repeat (8) tick();
        s_valid = 1'b0;
      end
      while (!s_ready) tick();
      if (mode[i] == 1 || mode[i] == 2) begin
        s_valid = 1'b1; s_data = val;
        tick();
        s_valid = 1'b0; s_data = 16'h0000;
        check(s_ready == 1'b0, "R6 ready low after transfer", s_ready, 0);
        last = val;
      end else begin
        hi_cnt = 0;
        while (s_ready) begin hi_cnt++; tick(); end
        if (mode[i] == 0)
          check(hi_cnt == 31 * 8 || i == 0, "R5 ready window cycles", hi_cnt, 31 * 8);
      end
      exp_q.push_back(last);
      while (s_ready) tick();
    end
  end

  // monitor: decodes half bits into frames and scores them
  initial begin
    logic prev_line, took, h0, lv;
    int halves, bitn, ones, glitches, mbad;
    logic [47:0] fr;
    wait (rst_n);
    #1;
    prev_line = line_out; h0 = line_out; halves = 1;
    bitn = 0; ones = 0; glitches = 0; mbad = 0; fr = '0;
    for (int f = 0; f < NFRAMES; ) begin
      @(posedge clk);
      took = half_en;
      #1;
      lv = line_out;
      if (!took) begin
        if (lv != prev_line) glitches++;
      end else begin
        if (halves == 0) begin
          h0 = lv; halves = 1;
        end else begin
          if (lv == h0) mbad++;
          ones += int'(h0) + int'(lv);
          fr = {fr[46:0], h0};
          bitn++; halves = 0;
          if (bitn == 48) begin
            logic [15:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
            check(fr[47:17] == 31'd0, "R2 zero run", int'(fr[47:17]), 0);
            check(fr[16] == 1'b1, "R2 start bit", fr[16], 1);
            check(fr[15:0] == e, "R7/R8/R9 data word MSB first", fr[15:0], e);
            check(mbad == 0, "R3 half complement", mbad, 0);
            check(ones == 48, "R3 high halves per frame", ones, 48);
            bitn = 0; ones = 0; mbad = 0; fr = '0;
            f++;
          end
        end
      end
      prev_line = lv;
    end
    check(glitches == 0, "R4 line changes only on strobe", glitches, 0);
    mon_done = 1'b1;
  end

  // watchdog and summary
  initial begin
    int cyc;
    cyc = 0;
    while (!mon_done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!mon_done) check(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule